// File: doc/BRIEF.md
# Shadow Array Store/Recall Engine

This block keeps a 2048-byte volatile working array beside a nonvolatile shadow array of the same size, both built from registers. A normal memory port reads and writes the working array. Two bulk transfers move the whole array at once. A store copies the working array into the shadow array. A recall copies the shadow array back into the working array. Each transfer runs two timed phases in a fixed order. A store erases the shadow array and then programs it. A recall clears the working array and then loads it.

A one-cycle command strobe with an operation select starts a transfer. A recall also starts by itself whenever the power-good input goes high, and on the first clock after reset if power-good is already high. While a transfer runs, `busy` is high, the port refuses every request, and no read response is produced. If power-good drops, the running transfer is abandoned. Phases that had already finished keep their effect. The block then stays idle until power-good returns, and that return starts the automatic recall.

The request side is a valid/ready handshake. The block alone applies back-pressure by holding `req_ready` low, and a request is taken only on a cycle where both signals are high. The response side has no ready. `rsp_valid` is a single-cycle pulse, and the consumer must take the data on that cycle.

Top module: `nvsh_engine`

## Requirements
- R1: While `rst_n` is low, `busy` and `rsp_valid` are 0. `req_ready` is 0 whenever `pwr_good` is 0.
- R2: `req_ready` is 1 only when the block is idle, `pwr_good` is 1, and no transfer is starting in that cycle. A write (`req_we`=1) updates the addressed byte at the accepting edge. A read (`req_we`=0) raises `rsp_valid` for exactly the next cycle, with the stored byte on `rsp_rdata`. `rsp_rdata` is 0 whenever `rsp_valid` is 0.
- R3: `cmd_stb` with `cmd_op`=0 (store), sampled while idle with `pwr_good` high, makes `busy` high from the next cycle for exactly ERASE_CYC+PROG_CYC cycles. Afterwards the shadow array holds the working array's contents.
- R4: A store erases every shadow byte to all ones at the end of its erase phase, and copies the working array into the shadow array only at the end of the following program phase.
- R5: `cmd_stb` with `cmd_op`=1 (recall) makes `busy` high for exactly CLEAR_CYC+COPY_CYC cycles. The working array is first cleared to zero and then loaded with the shadow contents.
- R6: A recall never alters the shadow array, so repeated recalls return the same data.
- R7: A rising `pwr_good`, or `pwr_good` already high on the first clock after reset, starts a recall with no command.
- R8: While `busy` is high, `req_ready` and `rsp_valid` stay 0, and requests held on the port have no effect on the working array.
- R9: Command strobes that arrive while `busy` is high are dropped. They neither lengthen the transfer nor start another after it.
- R10: `pwr_good` going low makes `busy` fall at the next edge. Only phases that had completed keep their effect on the arrays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| pwr_good | input | 1 | Supply-good indication; its rise triggers a recall |
| cmd_stb | input | 1 | Transfer command strobe |
| cmd_op | input | 1 | Operation select: 0 store, 1 recall |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high together with req_valid |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 8 | Read data, 0 when rsp_valid is low |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that `cmd_stb`, `cmd_op`, `pwr_good` and the request fields change only between clock edges, and that every phase length parameter is at least one. The bench drives every input on the falling edge and samples on the falling edge. It holds requests and strobes on the port during transfers on purpose, so that the blocking and dropping rules are exercised. It changes `pwr_good` at chosen busy-cycle counts, so that each abort lands inside a known phase.

// File: rtl/nvsh_pkg.sv
package nvsh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef enum logic {
    OP_STORE  = 1'b0,
    OP_RECALL = 1'b1
  } op_e;
endpackage

// File: rtl/nvsh_seq.sv
module nvsh_seq
  import nvsh_pkg::*;
#(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 20,
  parameter int CLEAR_CYC = 6,
  parameter int COPY_CYC  = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_good,
  input  logic   cmd_stb,
  input  logic   cmd_op,
  output phase_e phase,
  output op_e    op,
  output logic   launch,
  output logic   first_done,
  output logic   second_done
);
  localparam int MAX_S = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_R = (CLEAR_CYC > COPY_CYC) ? CLEAR_CYC : COPY_CYC;
  localparam int MAXC  = (MAX_S > MAX_R) ? MAX_S : MAX_R;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;

  phase_e        phase_q;
  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          pg_q;
  op_e           start_op;
  logic          cnt_zero;

  function automatic logic [CW-1:0] first_len(op_e o);
    return (o == OP_RECALL) ? CW'(CLEAR_CYC - 1) : CW'(ERASE_CYC - 1);
  endfunction

  function automatic logic [CW-1:0] second_len(op_e o);
    return (o == OP_RECALL) ? CW'(COPY_CYC - 1) : CW'(PROG_CYC - 1);
  endfunction

  // Automatic recall takes priority over a command arriving in the same cycle.
  assign start_op    = (!pg_q) ? OP_RECALL : op_e'(cmd_op);
  assign launch      = (phase_q == PH_IDLE) && pwr_good && (cmd_stb || !pg_q);
  assign cnt_zero    = (cnt_q == '0);
  assign first_done  = pwr_good && (phase_q == PH_FIRST)  && cnt_zero;
  assign second_done = pwr_good && (phase_q == PH_SECOND) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_STORE;
      cnt_q   <= '0;
      pg_q    <= 1'b0;
    end else begin
      pg_q <= pwr_good;
      if (!pwr_good) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            if (launch) begin
              phase_q <= PH_FIRST;
              op_q    <= start_op;
              cnt_q   <= first_len(start_op);
            end
          end
          PH_FIRST: begin
            if (cnt_zero) begin
              phase_q <= PH_SECOND;
              cnt_q   <= second_len(op_q);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_SECOND: begin
            if (cnt_zero) phase_q <= PH_IDLE;
            else          cnt_q   <= cnt_q - 1'b1;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase = phase_q;
  assign op    = op_q;

  // R10: loss of power-good ends any transfer at the next edge
  a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (phase_q == PH_IDLE));

  // R7: a power-good rise starts a recall
  a_r7_auto_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !pg_q) |=> (phase_q == PH_FIRST && op_q == OP_RECALL));

  // R9: the operation of a running transfer is never replaced
  a_r9_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && pwr_good) |=> $stable(op_q));

  // R4: the second phase is only entered from the first
  a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_SECOND) |-> ($past(phase_q) == PH_FIRST));
endmodule

// File: rtl/nvsh_access.sv
module nvsh_access
  import nvsh_pkg::*;
(
  input  phase_e phase,
  input  logic   pwr_good,
  input  logic   launch,
  input  logic   req_valid,
  input  logic   req_we,
  output logic   req_ready,
  output logic   wr_fire,
  output logic   rd_fire
);
  // Refuse access in a cycle that launches a transfer so no response overlaps busy.
  assign req_ready = (phase == PH_IDLE) && pwr_good && !launch;
  assign wr_fire   = req_valid && req_ready && req_we;
  assign rd_fire   = req_valid && req_ready && !req_we;
endmodule

// File: rtl/nvsh_arrays.sv
module nvsh_arrays
  import nvsh_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              first_done,
  input  logic              second_done,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] work_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              rv_q;

  logic do_clear, do_load, do_erase, do_prog;
  assign do_clear = first_done  && (op == OP_RECALL);
  assign do_load  = second_done && (op == OP_RECALL);
  assign do_erase = first_done  && (op == OP_STORE);
  assign do_prog  = second_done && (op == OP_STORE);

  // Working array: volatile, no reset
  always_ff @(posedge clk) begin
    if (do_clear) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= '0;
    end else if (do_load) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= shadow_q[i];
    end else if (wr_fire) begin
      work_q[addr] <= wdata;
    end
  end

  // Shadow array: nonvolatile, only touched by store phases
  always_ff @(posedge clk) begin
    if (do_erase) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '1;
    end else if (do_prog) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= work_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rd_fire;
      if (rd_fire) rd_q <= work_q[addr];
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rv_q ? rd_q : '0;

  // R2: a response only follows an accepted read
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $past(rd_fire));

  // R8: bulk phases never coincide with an accepted write
  a_r8_bulk_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (first_done || second_done) |-> !wr_fire);
endmodule

// File: rtl/nvsh_engine.sv
module nvsh_engine
  import nvsh_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 20,
  parameter int CLEAR_CYC = 6,
  parameter int COPY_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cmd_stb,
  input  logic              cmd_op,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy
);
  phase_e phase;
  op_e    op;
  logic   launch, first_done, second_done, wr_fire, rd_fire;

  nvsh_seq #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLEAR_CYC(CLEAR_CYC), .COPY_CYC(COPY_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .phase(phase), .op(op), .launch(launch),
    .first_done(first_done), .second_done(second_done)
  );

  nvsh_access access_i (
    .phase(phase), .pwr_good(pwr_good), .launch(launch),
    .req_valid(req_valid), .req_we(req_we),
    .req_ready(req_ready), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  nvsh_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arrays_i (
    .clk(clk), .rst_n(rst_n), .op(op),
    .first_done(first_done), .second_done(second_done),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .addr(req_addr), .wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign busy = (phase != PH_IDLE);

  // R8: port is silent during a transfer
  a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!req_ready && !rsp_valid));

  // R1: no access without power-good
  a_r1_no_ready_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> !req_ready);
endmodule

// File: tb/nvsh_engine_tb_top.sv
`timescale 1ns/1ps
module nvsh_engine_tb_top;
  localparam int EC = 12, PC = 20, CC = 6, YC = 10;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        cmd_stb = 1'b0;
  logic        cmd_op = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  nvsh_engine #(
    .ERASE_CYC(EC), .PROG_CYC(PC), .CLEAR_CYC(CC), .COPY_CYC(YC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy)
  );

  function automatic logic [7:0] pat(int seed, int a);
    return 8'(a) ^ 8'(seed) ^ {3'(a >> 8), 5'b0};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(int seed);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b1;
      req_addr = 11'(a); req_wdata = pat(seed, a);
    end
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(int a, output logic v, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 11'(a);
    @(negedge clk);
    v = rsp_valid; d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  // mode 0: pattern with seed; mode 1: constant seed
  task automatic verify(string req, int mode, int seed);
    int bad = 0, ba = 0, bv = 0, be = 0;
    logic v; logic [7:0] d; logic [7:0] e;
    for (int a = 0; a < DEPTH; a += 61) begin
      for (int k = 0; k < 2; k++) begin
        int x = (k == 0) ? a : DEPTH - 1 - a;
        rd(x, v, d);
        e = (mode == 0) ? pat(seed, x) : 8'(seed);
        if (!v || d != e) begin
          if (bad == 0) begin ba = x; bv = d; be = e; end
          bad++;
        end
      end
    end
    chk(req, $sformatf("array contents (first bad addr %0h)", ba),
        (bad == 0) ? 0 : bv, (bad == 0) ? 0 : be);
  endtask

  task automatic issue(logic o);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = o;
    #1;
    chk("R2", "ready low in launch cycle", req_ready, 0);
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    chk("R1", "ready without power", req_ready, 0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R1", "busy held in reset", busy, 0);
  endtask

  task automatic t_powerup();
    int n;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "busy after reset release", busy, 1);
    count_busy(n);
    chk("R7", "auto recall length", n, CC + YC);
  endtask

  task automatic t_rw();
    logic v; logic [7:0] d;
    #1;
    chk("R2", "ready when idle", req_ready, 1);
    chk("R2", "rdata zero when no response", rsp_rdata, 0);
    fill(8'h3C);
    rd(11'h555, v, d);
    chk("R2", "rsp_valid one cycle after read", v, 1);
    chk("R2", "read data", d, pat(8'h3C, 11'h555));
    @(negedge clk);
    chk("R2", "rsp_valid single cycle", rsp_valid, 0);
    chk("R2", "rdata zero after response", rsp_rdata, 0);
    verify("R2", 0, 8'h3C);
  endtask

  task automatic t_store_recall();
    int n;
    issue(1'b0);
    count_busy(n);
    chk("R3", "store length", n, EC + PC);
    fill(8'hA5);
    issue(1'b1);
    count_busy(n);
    chk("R5", "recall length", n, CC + YC);
    verify("R3", 0, 8'h3C);
  endtask

  task automatic t_recall_repeat();
    int n;
    fill(8'h11);
    issue(1'b1);
    count_busy(n);
    verify("R6", 0, 8'h3C);
    fill(8'h22);
    issue(1'b1);
    count_busy(n);
    chk("R6", "second recall length", n, CC + YC);
    verify("R6", 0, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    int n = 0, rsp_seen = 0, rdy_seen = 0;
    logic v; logic [7:0] d;
    fill(8'h5A);
    issue(1'b0);
    while (busy && n < 1000) begin
      n++;
      if (rsp_valid) rsp_seen++;
      if (req_ready) rdy_seen++;
      if (n == 2) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = 11'h005; req_wdata = 8'hEE;
      end
      if (n == 5) begin cmd_stb = 1'b1; cmd_op = 1'b1; end
      if (n == 6) cmd_stb = 1'b0;
      if (n == EC + 3) begin cmd_stb = 1'b1; cmd_op = 1'b0; end
      if (n == EC + 4) cmd_stb = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0; req_we = 1'b0;
    chk("R9", "store length with stray strobes", n, EC + PC);
    chk("R8", "responses while busy", rsp_seen, 0);
    chk("R8", "ready while busy", rdy_seen, 0);
    @(negedge clk);
    chk("R9", "no transfer after dropped strobe", busy, 0);
    rd(11'h005, v, d);
    chk("R8", "blocked write had no effect", d, pat(8'h5A, 5));
  endtask

  task automatic abort_store_at(int cyc);
    int n = 0;
    issue(1'b0);
    while (n < cyc - 1) begin n++; @(negedge clk); end
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R10", "busy falls after power loss", busy, 0);
    chk("R10", "ready low without power", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10", "stays idle unpowered", busy, 0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R7", "recall on power return", busy, 1);
    count_busy(n);
    chk("R7", "power return recall length", n, CC + YC);
  endtask

  task automatic t_abort_program();
    fill(8'h77);
    abort_store_at(EC + 2);
    verify("R4", 1, 8'hFF);
  endtask

  task automatic t_abort_erase();
    int n;
    fill(8'h42);
    issue(1'b0);
    count_busy(n);
    fill(8'h99);
    abort_store_at(2);
    verify("R10", 0, 8'h42);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_rw();
    t_store_recall();
    t_recall_repeat();
    t_busy_ignore();
    t_abort_program();
    t_abort_erase();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule